// File: doc/BRIEF.md
# LED Channel Dimmer with Shared Group Dim/Blink

This block drives a bank of LED channels through active-low sink enables, which model open-drain drivers. Each channel has a fast pulse-width modulator with a brightness register of `BW` bits. All channels run from one free-running counter, so every channel's period is 2^BW clocks. A slower shared group modulator with its own duty value sits on top of the channel modulators. It works as a global dimmer at a fixed rate of one step every 2^DIM_PRE_W channel periods. As a blinker, it takes one step every (period + 1) × 2^BLINK_PRE_W channel periods.

A 2-bit mode per channel picks how the channel is driven: dark, solid on, its own modulator only, or its own modulator gated by the group modulator. An active-low enable input blanks every output. Mode and brightness are captured only at a channel-period boundary, and the group duty only at a group-period boundary, so that an update never produces a runt pulse. With a 25 MHz clock and default parameters, the channel rate is about 97.7 kHz. The dimmer rate is then about 190 Hz, and the blink period spans about 42 ms to 10.7 s.

Top module: `led_dimmer_bank`

## Requirements
- R1: During reset and in the first channel period after it, every `led_n` bit is 1 (not sinking).
- R2: In mode 2'b10 (own modulator), a channel sinks for exactly B cycles of each 2^BW-cycle period, where B is its brightness (0 gives none).
- R3: Mode 2'b00 keeps the channel at 1 every cycle; mode 2'b01 keeps it at 0 every cycle of a period.
- R4: In mode 2'b11, the channel sinks only where its own modulator and the group modulator are both active. Over one group period it sinks B × G × (step length in periods) cycles, where G is the group duty.
- R5: With `blink_en` = 0, the group modulator has 2^BW steps, each lasting 2^DIM_PRE_W channel periods.
- R6: With `blink_en` = 1, each group step lasts (P + 1) × 2^BLINK_PRE_W channel periods, where P is `grp_period`.
- R7: While `oe_n` is 1, all outputs are 1 from the next cycle on; they resume the modulated state one cycle after `oe_n` returns to 0.
- R8: A mode or brightness change applied within a channel period leaves the rest of that period unchanged; the change takes effect at the next period.
- R9: The group duty is captured at a group-period wrap; from reset until the first wrap, it acts as full scale (all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable; 1 blanks all channels |
| chan_mode | input | NUM_CH*2 | Per-channel mode, channel i at bits [2i+1:2i] |
| chan_bri | input | NUM_CH*BW | Per-channel brightness, channel i at bits [BW*i+BW-1:BW*i] |
| grp_duty | input | BW | Group duty value |
| grp_period | input | BW | Blink step length, minus one, in blink ticks |
| blink_en | input | 1 | 0 = group dims, 1 = group blinks |
| led_n | output | NUM_CH | Active-low sink enable per channel |

## Verification
Each output is registered, so `led_n` shows the state from one clock after the counter value and the shadow registers that produce it. A change of `oe_n` appears one cycle later. New channel settings take effect from the first sample after the period's last counter edge. A new group duty takes effect only after the next group wrap.

Duty checks therefore count sinking cycles over a whole period of the signal being measured, which makes them independent of phase. Before counting, the bench waits at least one full group period after a change, so that the shadow registers have been reloaded. The mid-period update check follows the number of edges since reset. It applies the change at a known counter position and inspects exactly the remaining samples of that period.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    typedef enum logic [1:0] {
        CH_OFF = 2'b00,
        CH_ON  = 2'b01,
        CH_IND = 2'b10,
        CH_MIX = 2'b11
    } ch_mode_e;

    typedef struct packed {
        logic frame_end;
        logic grp_wrap;
    } tick_t;

    function automatic logic mode_drive(ch_mode_e m, logic own_on, logic grp_on);
        case (m)
            CH_ON:   return 1'b1;
            CH_IND:  return own_on;
            CH_MIX:  return own_on & grp_on;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase
    import led_pwm_pkg::*;
#(
    parameter int BW          = 8,
    parameter int DIM_PRE_W   = 9,
    parameter int BLINK_PRE_W = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blink_en,
    input  logic [BW-1:0] grp_period,
    output logic [BW-1:0] cnt,
    output logic [BW-1:0] gcnt,
    output tick_t         ticks
);
    localparam int PW = (DIM_PRE_W > BLINK_PRE_W) ? DIM_PRE_W : BLINK_PRE_W;

    logic [PW-1:0] pre;
    logic [BW-1:0] stepcnt;
    logic frame_end, dim_step, blink_tick, blink_step, step;

    always_comb begin
        frame_end  = &cnt;
        dim_step   = frame_end && (&pre[DIM_PRE_W-1:0]);
        blink_tick = frame_end && (&pre[BLINK_PRE_W-1:0]);
        blink_step = blink_tick && (stepcnt >= grp_period);
        step       = blink_en ? blink_step : dim_step;
        ticks.frame_end = frame_end;
        ticks.grp_wrap  = step && (&gcnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pre     <= '0;
            stepcnt <= '0;
            gcnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (frame_end) pre <= pre + 1'b1;
            if (blink_tick) stepcnt <= (stepcnt >= grp_period) ? '0 : stepcnt + 1'b1;
            if (step) gcnt <= gcnt + 1'b1;
        end
    end

    // group steps only advance on a channel-period boundary
    assert_group_step_on_frame_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(gcnt));

endmodule

// File: rtl/led_group_pwm.sv
module led_group_pwm #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] gcnt,
    input  logic          grp_wrap,
    input  logic [BW-1:0] grp_duty,
    output logic          grp_on
);
    logic [BW-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst)           duty_q <= '1;
        else if (grp_wrap) duty_q <= grp_duty;
    end

    assign grp_on = gcnt < duty_q;

    assert_duty_held_R9: assert property (@(posedge clk) disable iff (rst)
        !grp_wrap |=> $stable(duty_q));

endmodule

// File: rtl/led_channel.sv
module led_channel
    import led_pwm_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] cnt,
    input  logic          frame_end,
    input  logic          grp_on,
    input  logic          oe_n,
    input  ch_mode_e      mode_in,
    input  logic [BW-1:0] bri_in,
    output logic          led_n
);
    ch_mode_e      mode_q;
    logic [BW-1:0] bri_q;
    logic          on;

    always_comb on = mode_drive(mode_q, cnt < bri_q, grp_on);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CH_OFF;
            bri_q  <= '0;
            led_n  <= 1'b1;
        end else begin
            if (frame_end) begin
                mode_q <= mode_in;
                bri_q  <= bri_in;
            end
            led_n <= ~(on & ~oe_n);
        end
    end

    assert_latch_on_frame_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(mode_q) && $stable(bri_q)));

    assert_off_mode_dark_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CH_OFF) |=> led_n);

    assert_blank_on_oe_R7: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> led_n);

    assert_zero_bri_dark_R2: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == CH_IND || mode_q == CH_MIX) && bri_q == '0) |=> led_n);

endmodule

// File: rtl/led_dimmer_bank.sv
module led_dimmer_bank
    import led_pwm_pkg::*;
#(
    parameter int NUM_CH      = 24,
    parameter int BW          = 8,
    parameter int DIM_PRE_W   = 9,
    parameter int BLINK_PRE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oe_n,
    input  logic [NUM_CH*2-1:0]  chan_mode,
    input  logic [NUM_CH*BW-1:0] chan_bri,
    input  logic [BW-1:0]        grp_duty,
    input  logic [BW-1:0]        grp_period,
    input  logic                 blink_en,
    output logic [NUM_CH-1:0]    led_n
);
    logic [BW-1:0] cnt, gcnt;
    tick_t         ticks;
    logic          grp_on;

    led_pwm_timebase #(.BW(BW), .DIM_PRE_W(DIM_PRE_W), .BLINK_PRE_W(BLINK_PRE_W)) u_tb (
        .clk(clk), .rst(rst), .blink_en(blink_en), .grp_period(grp_period),
        .cnt(cnt), .gcnt(gcnt), .ticks(ticks)
    );

    led_group_pwm #(.BW(BW)) u_grp (
        .clk(clk), .rst(rst), .gcnt(gcnt), .grp_wrap(ticks.grp_wrap),
        .grp_duty(grp_duty), .grp_on(grp_on)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        led_channel #(.BW(BW)) u_ch (
            .clk(clk), .rst(rst), .cnt(cnt), .frame_end(ticks.frame_end),
            .grp_on(grp_on), .oe_n(oe_n),
            .mode_in(ch_mode_e'(chan_mode[2*i +: 2])),
            .bri_in(chan_bri[BW*i +: BW]),
            .led_n(led_n[i])
        );
    end

    assert_reset_dark_R1: assert property (@(posedge clk) rst |=> (&led_n));

endmodule

// File: tb/sim_led_dimmer_bank.sv
module sim_led_dimmer_bank;
    localparam int NCH = 4;
    localparam int BW  = 4;
    localparam int DPW = 1;
    localparam int BPW = 1;
    localparam int FR  = 1 << BW;
    localparam int GP  = FR * FR * (1 << DPW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oe_n = 1'b0;
    logic [NCH*2-1:0]  chan_mode = '0;
    logic [NCH*BW-1:0] chan_bri = '0;
    logic [BW-1:0] grp_duty = '0;
    logic [BW-1:0] grp_period = '0;
    logic blink_en = 1'b0;
    logic [NCH-1:0] led_n;

    int checks = 0;
    int fails = 0;
    int edge_n = -1;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edge_n <= -1;
        else     edge_n <= edge_n + 1;
    end

    led_dimmer_bank #(.NUM_CH(NCH), .BW(BW), .DIM_PRE_W(DPW), .BLINK_PRE_W(BPW)) u0 (
        .clk(clk), .rst(rst), .oe_n(oe_n), .chan_mode(chan_mode), .chan_bri(chan_bri),
        .grp_duty(grp_duty), .grp_period(grp_period), .blink_en(blink_en), .led_n(led_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input logic [1:0] m, input int b);
        chan_mode[2*ch +: 2] = m;
        chan_bri[BW*ch +: BW] = BW'(b);
    endtask

    task automatic count_on(input int ch, input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!led_n[ch]) c++;
        end
    endtask

    task automatic wait_pos(input int p);
        do @(negedge clk); while ((edge_n % FR) != p);
    endtask

    task automatic t_reset_R1_R9();
        int c;
        int dark;
        set_ch(0, 2'b11, 15);
        grp_duty = '0;
        dark = 1;
        repeat (3) begin
            @(negedge clk);
            if (led_n != '1) dark = 0;
        end
        rst = 1'b0;
        for (int k = 0; k < FR; k++) begin
            @(negedge clk);
            if (led_n != '1) dark = 0;
        end
        chk("R1 outputs dark in and after reset", dark, 1);
        count_on(0, GP - FR, c);
        chk("R9 full-scale group duty before first wrap", c, 29 * 15);
        count_on(0, GP, c);
        chk("R9 captured zero duty after wrap", c, 0);
    endtask

    task automatic t_ind_R2_R3();
        int c;
        int bl [4] = '{0, 1, 7, 15};
        set_ch(0, 2'b00, 15);
        set_ch(2, 2'b01, 0);
        foreach (bl[i]) begin
            set_ch(1, 2'b10, bl[i]);
            count_on(1, 2 * FR, c);
            count_on(1, FR, c);
            chk($sformatf("R2 own duty b=%0d", bl[i]), c, bl[i]);
        end
        count_on(0, FR, c);
        chk("R3 off mode never sinks", c, 0);
        count_on(2, FR, c);
        chk("R3 on mode sinks every cycle", c, FR);
    endtask

    task automatic t_group_R4_R5_R6();
        int c;
        grp_duty = 4'd8;
        blink_en = 1'b0;
        set_ch(0, 2'b11, 15);
        set_ch(3, 2'b11, 5);
        repeat (2 * GP) @(negedge clk);
        count_on(0, GP, c);
        chk("R4 R5 mixed duty dim b=15", c, 15 * 8 * 2);
        count_on(3, GP, c);
        chk("R4 R5 mixed duty dim b=5", c, 5 * 8 * 2);
        blink_en = 1'b1;
        grp_period = 4'd2;
        repeat (2 * FR * FR * 3 * 2) @(negedge clk);
        count_on(0, FR * FR * 3 * 2, c);
        chk("R6 blink step length P=2", c, 15 * 8 * 3 * 2);
        blink_en = 1'b0;
    endtask

    task automatic t_oe_R7();
        int ok;
        set_ch(2, 2'b01, 0);
        repeat (2 * FR) @(negedge clk);
        oe_n = 1'b1;
        @(negedge clk);
        chk("R7 blank one cycle after oe_n high", int'(led_n), (1 << NCH) - 1);
        ok = 1;
        repeat (5) begin
            @(negedge clk);
            if (led_n != '1) ok = 0;
        end
        chk("R7 blank held while oe_n high", ok, 1);
        oe_n = 1'b0;
        @(negedge clk);
        chk("R7 on channel resumes", int'(led_n[2]), 0);
    endtask

    task automatic t_latch_R8();
        int c;
        wait_pos(FR - 2);
        set_ch(1, 2'b10, 4);
        wait_pos(FR - 2);
        wait_pos(7);
        set_ch(1, 2'b10, 12);
        count_on(1, FR - 8, c);
        chk("R8 brightness change deferred", c, 0);
        count_on(1, FR, c);
        chk("R8 new brightness next period", c, 12);
        wait_pos(3);
        set_ch(1, 2'b00, 12);
        count_on(1, FR - 4, c);
        chk("R8 mode change deferred", c, 8);
        count_on(1, FR, c);
        chk("R8 new mode next period", c, 0);
    endtask

    initial begin
        t_reset_R1_R9();
        t_ind_R2_R3();
        t_group_R4_R5_R6();
        t_oe_R7();
        t_latch_R8();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule